// File: doc/BRIEF.md
# Broadcast Group-Membership Address Filter

This block sits on the receive side of a node that listens to broadcast commands. Each command packet names the nodes that must act on it. The filter takes the packet payload one byte at a time, together with the node's own identifier from a configuration input. When the packet ends, it gives a one-cycle verdict saying whether this node is addressed. Command decoding and integrity checking happen elsewhere.

Two addressing formats share the same packet layout. The most significant bit of the first payload byte selects the format. When that bit is clear, the payload is a membership bitmap with one bit per node. The selector bit occupies the first bitmap position, so the first byte carries only seven node bits, and every node's bit sits one position later than its identifier. When the selector bit is set, the byte after the first one carries the identifier of the single addressed node, and the filter matches only on equality.

Top module: `grp_addr_filter`

## Requirements
- R1: While reset is asserted, and after it is released until the first packet ends, `match_o` is low.
- R2: `match_o` is registered. It is high only in the cycle that directly follows an accepted byte with `in_last` high, and it is high for that one cycle only.
- R3: Bit 7 of the first payload byte selects the format: 0 selects bitmap mode and 1 selects single-node mode.
- R4: In bitmap mode, node n owns stream bit position p = n + 1, where bytes are taken in arrival order and bits are taken from bit 7 down to bit 0. That bit lives in byte p / 8 at bit 7 - (p mod 8). The node matches exactly when that bit is 1.
- R5: In bitmap mode, if the packet has no byte at index (n + 1) / 8, the node does not match.
- R6: In bitmap mode, bits that belong to other nodes have no effect on the verdict.
- R7: In single-node mode, the node matches exactly when the second payload byte (index 1) equals `cfg_node_id`. Bits 6..0 of the first byte are ignored.
- R8: In single-node mode, a packet without a second byte does not match. Bytes after index 1 are ignored, even when they equal `cfg_node_id`.
- R9: A byte is accepted only in a cycle with `in_valid` high. In cycles with `in_valid` low, `in_data` and `in_last` have no effect.
- R10: Each packet is judged on its own. This holds for back-to-back packets, including one-byte packets on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_node_id | input | ID_W (8) | This node's identifier, held stable while a packet is in flight |
| in_valid | input | 1 | Payload byte strobe |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of a packet, qualified by `in_valid` |
| match_o | output | 1 | One-cycle pulse after the last byte when this node is addressed |

## Verification
The bound checker follows packet boundaries and the latched format from the ports alone. On every cycle it checks the following:
- The verdict only ever follows a last byte.
- One-byte single-node packets never match.
- In a two-byte single-node packet, the verdict equals the comparison of byte 1 with the identifier.
- A one-byte bitmap packet matches exactly when the node's bit in byte 0 is set.

Only the directed scenarios can show the other behaviours: bit positions deep in long bitmaps, including the highest identifier in byte 32; bitmaps too short for the node; trailing bytes that are ignored; idle gaps carrying garbage; and pulse width across back-to-back packets.

// File: rtl/gaf_pkg.sv
package gaf_pkg;

  // Payload lane width; the format selector is its top bit.
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANE_LG = $clog2(LANE_W);

  typedef enum logic {
    FMT_BITMAP = 1'b0,
    FMT_SINGLE = 1'b1
  } gaf_fmt_e;

  // Stream bit position of a node: one past its identifier, since the
  // selector bit takes position zero.
  function automatic int unsigned node_stream_pos(input int unsigned node);
    return node + 1;
  endfunction

endpackage

// File: rtl/gaf_rst_sync.sv
module gaf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gaf_target_locator.sv
module gaf_target_locator
  import gaf_pkg::*;
#(
  parameter int unsigned ID_W  = 8,
  parameter int unsigned IDX_W = ID_W + 1 - LANE_LG
) (
  input  logic [ID_W-1:0]   node_id,
  output logic [IDX_W-1:0]  tgt_byte,
  output logic [LANE_W-1:0] tgt_mask
);

  localparam int unsigned POS_W = ID_W + 1;

  logic [POS_W-1:0]   pos;
  logic [LANE_LG-1:0] bit_sel;

  always_comb begin
    pos      = {1'b0, node_id} + POS_W'(1);
    tgt_byte = pos[POS_W-1:LANE_LG];
    bit_sel  = pos[LANE_LG-1:0];
    // Bits are taken MSB first within each byte.
    tgt_mask = {1'b1, {(LANE_W-1){1'b0}}} >> bit_sel;
  end

endmodule

// File: rtl/gaf_byte_tracker.sv
module gaf_byte_tracker #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             beat_last,
  output logic [CNT_W-1:0] byte_idx,
  output logic             first_byte
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = beat;
    cnt_d  = cnt_q;
    if (beat_last) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      // Saturate so an overlong packet never aliases back onto a target.
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign byte_idx   = cnt_q;
  assign first_byte = (cnt_q == '0);

endmodule

// File: rtl/gaf_verdict.sv
module gaf_verdict
  import gaf_pkg::*;
#(
  parameter int unsigned ID_W  = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              beat_last,
  input  logic [LANE_W-1:0] data,
  input  logic              first_byte,
  input  logic [CNT_W-1:0]  byte_idx,
  input  logic [CNT_W-1:0]  tgt_byte,
  input  logic [LANE_W-1:0] tgt_mask,
  input  logic [ID_W-1:0]   node_id,
  output logic              match_o
);

  gaf_fmt_e         fmt_q, fmt_d, fmt_now;
  logic             acc_q, acc_d;
  logic             match_q, match_d;
  logic             hit_bitmap, hit_single, hit_beat, hit_pkt;
  logic [LANE_W-1:0] id_lane;

  always_comb begin
    id_lane = LANE_W'(node_id);
    fmt_now = first_byte ? gaf_fmt_e'(data[LANE_W-1]) : fmt_q;

    hit_bitmap = (fmt_now == FMT_BITMAP) && (byte_idx == tgt_byte)
                 && ((data & tgt_mask) != '0);
    hit_single = (fmt_now == FMT_SINGLE) && (byte_idx == CNT_W'(1))
                 && (data == id_lane);
    hit_beat   = hit_bitmap || hit_single;
    hit_pkt    = first_byte ? hit_beat : (acc_q || hit_beat);

    fmt_d   = fmt_q;
    acc_d   = acc_q;
    match_d = 1'b0;
    if (beat) begin
      if (beat_last) begin
        fmt_d   = FMT_BITMAP;
        acc_d   = 1'b0;
        match_d = hit_pkt;
      end else begin
        fmt_d = fmt_now;
        acc_d = hit_pkt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_BITMAP;
      acc_q <= 1'b0;
    end else if (beat) begin
      fmt_q <= fmt_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= match_d;
    end
  end

  assign match_o = match_q;

endmodule

// File: rtl/grp_addr_filter.sv
module grp_addr_filter
  import gaf_pkg::*;
#(
  parameter int unsigned ID_W       = 8,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] cfg_node_id,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            match_o
);

  localparam int unsigned IDX_W = ID_W + 1 - LANE_LG;

  logic             rst_core_n;
  logic [IDX_W-1:0] byte_idx;
  logic             first_byte;
  logic [IDX_W-1:0] tgt_byte;
  logic [LANE_W-1:0] tgt_mask;
  logic             beat;
  logic             beat_last;

  assign beat      = in_valid;
  assign beat_last = in_valid && in_last;

  gaf_rst_sync #(
    .STAGES(SYNC_STAGE)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  gaf_target_locator #(
    .ID_W (ID_W),
    .IDX_W(IDX_W)
  ) u_locator (
    .node_id (cfg_node_id),
    .tgt_byte(tgt_byte),
    .tgt_mask(tgt_mask)
  );

  gaf_byte_tracker #(
    .CNT_W(IDX_W)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .beat      (beat),
    .beat_last (beat_last),
    .byte_idx  (byte_idx),
    .first_byte(first_byte)
  );

  gaf_verdict #(
    .ID_W (ID_W),
    .CNT_W(IDX_W)
  ) u_verdict (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .beat      (beat),
    .beat_last (beat_last),
    .data      (in_data),
    .first_byte(first_byte),
    .byte_idx  (byte_idx),
    .tgt_byte  (tgt_byte),
    .tgt_mask  (tgt_mask),
    .node_id   (cfg_node_id),
    .match_o   (match_o)
  );

endmodule

// File: rtl/grp_addr_filter_chk.sv
module grp_addr_filter_chk #(
  parameter int unsigned ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ID_W-1:0] cfg_node_id,
  input logic            in_valid,
  input logic [7:0]      in_data,
  input logic            in_last,
  input logic            match_o
);

  // Packet tracking built from the ports only.
  logic       mid_q;
  logic       single_q;
  logic [1:0] cnt_q;
  logic       own_bit0;
  logic       id_small;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q    <= 1'b0;
      single_q <= 1'b0;
      cnt_q    <= 2'd0;
    end else if (in_valid) begin
      if (in_last) begin
        mid_q <= 1'b0;
        cnt_q <= 2'd0;
      end else begin
        mid_q <= 1'b1;
        if (!mid_q) single_q <= in_data[7];
        if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  always_comb begin
    id_small = (32'(cfg_node_id) < 32'd7);
    own_bit0 = id_small ? in_data[3'd6 - 3'(cfg_node_id)] : 1'b0;
  end

  p_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(in_valid && in_last));

  p_single_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !mid_q && in_data[7]) |=> !match_o);

  p_single_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && mid_q && single_q && cnt_q == 2'd1)
      |=> (match_o == $past(32'(in_data) == 32'(cfg_node_id))));

  p_bitmap_byte0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !mid_q && !in_data[7])
      |=> (match_o == $past(own_bit0)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !match_o);

endmodule

bind grp_addr_filter grp_addr_filter_chk #(.ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .cfg_node_id(cfg_node_id),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_last    (in_last),
  .match_o    (match_o)
);

// File: tb/grp_addr_filter_bench.sv
`timescale 1ns/1ps
module grp_addr_filter_bench;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_node_id;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       match_o;

  int n_chk;
  int n_bad;
  logic [7:0] pkt [0:39];

  grp_addr_filter u_grp_addr_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_node_id(cfg_node_id),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .match_o    (match_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // Expected verdict from the format rules alone.
  function automatic logic model(input int len, input int id);
    int p;
    if (len == 0) return 1'b0;
    if (pkt[0][7]) return (len >= 2) && (pkt[1] == 8'(id));
    p = id + 1;
    if (p / 8 >= len) return 1'b0;
    return pkt[p/8][7 - (p % 8)];
  endfunction

  task automatic clear_pkt(input logic [7:0] fill);
    for (int i = 0; i < 40; i++) pkt[i] = fill;
  endtask

  task automatic run_pkt(input string req, input int len, input int id, input int gap);
    logic exp;
    @(negedge clk);
    cfg_node_id = 8'(id);
    exp = model(len, id);
    for (int i = 0; i < len; i++) begin
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0; in_data = 8'hFF; in_last = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    check(req, match_o, exp);
    @(negedge clk);
    check({req, "/R2 pulse"}, match_o, 1'b0);
  endtask

  task automatic t_reset();
    in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; cfg_node_id = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", match_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", match_o, 1'b0);
  endtask

  task automatic t_bitmap_own_bit();
    int ids[6] = '{0, 6, 7, 14, 100, 255};
    foreach (ids[k]) begin
      int p = ids[k] + 1;
      clear_pkt(8'h00);
      pkt[p/8][7 - p%8] = 1'b1;
      run_pkt("R4 own bit set", 33, ids[k], 0);
    end
  endtask

  task automatic t_bitmap_others();
    int ids[4] = '{0, 7, 63, 255};
    foreach (ids[k]) begin
      int p = ids[k] + 1;
      clear_pkt(8'hFF);
      pkt[0][7] = 1'b0;
      pkt[p/8][7 - p%8] = 1'b0;
      run_pkt("R6 others set, own clear", 33, ids[k], 0);
    end
    clear_pkt(8'h00);
    pkt[1] = 8'b0100_0000;          // bit for node 8, queried by node 7
    run_pkt("R6 neighbour bit", 2, 7, 0);
    clear_pkt(8'h00);
    pkt[0] = 8'h01;                 // node 6 bit
    run_pkt("R3 bitmap byte0", 1, 6, 0);
  endtask

  task automatic t_bitmap_short();
    clear_pkt(8'h7F);
    run_pkt("R5 short bitmap id 7", 1, 7, 0);
    clear_pkt(8'h7F);
    run_pkt("R5 short bitmap id 255", 32, 255, 0);
    clear_pkt(8'h7F);
    pkt[32] = 8'hFF;
    run_pkt("R5 exact length id 255", 33, 255, 0);
  endtask

  task automatic t_single();
    clear_pkt(8'h00);
    pkt[0] = 8'h80; pkt[1] = 8'd200;
    run_pkt("R7 single equal", 2, 200, 0);
    pkt[0] = 8'hFF; pkt[1] = 8'd7;
    run_pkt("R7 byte0 low bits ignored", 2, 7, 0);
    pkt[0] = 8'h80; pkt[1] = 8'd201;
    run_pkt("R7 single differ", 2, 200, 0);
    pkt[0] = 8'h80; pkt[1] = 8'd3; pkt[2] = 8'd9; pkt[3] = 8'd9;
    run_pkt("R8 trailing equal ignored", 4, 9, 0);
    pkt[0] = 8'h80; pkt[1] = 8'd9; pkt[2] = 8'd0;
    run_pkt("R8 trailing after hit", 3, 9, 0);
    pkt[0] = 8'h80;
    run_pkt("R8 single no id byte", 1, 0, 0);
  endtask

  task automatic t_gaps();
    int p = 41;
    clear_pkt(8'h00);
    pkt[p/8][7 - p%8] = 1'b1;
    run_pkt("R9 bitmap with gaps", 6, 40, 2);
    clear_pkt(8'h00);
    pkt[0] = 8'h80; pkt[1] = 8'd17;
    run_pkt("R9 single with gaps", 2, 17, 3);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    cfg_node_id = 8'd3;
    in_valid = 1'b1; in_data = 8'h08; in_last = 1'b1;   // node 3 bit
    @(negedge clk);
    in_data = 8'h8F;                                      // single, one byte
    check("R10 first of pair", match_o, 1'b1);
    @(negedge clk);
    in_data = 8'h08;
    check("R10 second of pair", match_o, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check("R10 third of pair", match_o, 1'b1);
    @(negedge clk);
    check("R10/R2 quiet after", match_o, 1'b0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_bitmap_own_bit();
    t_bitmap_others();
    t_bitmap_short();
    t_single();
    t_gaps();
    t_back2back();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule